// File: doc/BRIEF.md
# Dual-Device Bus Strobe Timer

This block generates the read and write strobes for programmed-I/O and multiword DMA cycles on a parallel storage bus that carries two devices. Each device has its own 32-bit timing word. One word holds a PIO pair (access ticks, recovery ticks) and a DMA triple (access ticks, recovery ticks, half-tick flag). A device-select register picks which device's word drives the bus. One clock period is one timing tick, which is 30 ns in the intended system.

A bus master raises `req_valid` and says whether the cycle is a write and whether it is a DMA cycle. The block then drives the chosen strobe for the access phase and holds it low for the recovery phase. After that it pulses `req_ack` for one clock. The timing word is sampled when the cycle begins, so configuration writes made during a cycle only apply from the next cycle. In a DMA cycle the half-tick flag stretches the strobe by half a clock. It does this by releasing the strobe on the falling edge that follows the last access tick.

Top module: `stb_timer`

## Requirements
- R1: After reset both strobes and `req_ack` are low. Both timing words and the select register reset to zero, so the first cycle uses one access tick and one recovery tick.
- R2: Configuration writes use `cfg_addr`: 0 writes the device-0 word, 1 writes the device-1 word, and 2 writes the select register. The device-1 word is used when bit 4 of the select register is 1. Otherwise the device-0 word is used. The other select bits have no effect.
- R3: In a PIO cycle the strobe rises on the clock edge after the one that sampled `req_valid`. It stays high for max(1, word[4:0]) clocks.
- R4: After the access phase the strobe stays low for max(1, word[9:5]) clocks. `req_ack` rises at the end of that interval and lasts exactly one clock.
- R5: A DMA cycle (`req_dma`=1) takes its access count from word[15:11] and its recovery count from word[20:16], each clamped to a minimum of 1.
- R6: In a DMA cycle with word[21] set, the strobe stays high for an extra half clock, until the next falling edge. In a PIO cycle, bit 21 has no effect.
- R7: `req_write`=1 drives only `wr_stb`, and `req_write`=0 drives only `rd_stb`. The two strobes are never high together.
- R8: A timing-word or select write that lands during a cycle does not change that cycle. The next cycle uses the new value.
- R9: While `req_ack` is high no new cycle starts. If the request is still held, the next access phase begins one clock after `req_ack` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0: device-0 word, 1: device-1 word, 2: select register |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Cycle request, held until acknowledged |
| req_dma | input | 1 | 1 selects the DMA fields, 0 the PIO fields |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| req_ack | output | 1 | One-clock pulse at the end of recovery |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |

## Verification
The bound checker checks on every clock that:
- the strobes are mutually exclusive;
- the acknowledge is a single pulse with no strobe in its cycle or in the one after it;
- a cycle start always raises the core strobe;
- the latched timing word stays constant for the whole cycle, even while the configuration port is being written.

Some properties are beyond the checker and come only from the bench scenarios:
- the exact lengths of the access and recovery phases;
- the choice of device word and field set;
- the half-clock stretch, which the bench measures by sampling twice per clock;
- the clamping of zero counts.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int WORD_W       = 32;
  localparam int TICK_W       = 5;
  localparam int SEL_W        = 8;
  localparam int SEL_DEV_BIT  = 4;
  localparam int PIO_ACC_LSB  = 0;
  localparam int PIO_REC_LSB  = 5;
  localparam int DMA_ACC_LSB  = 11;
  localparam int DMA_REC_LSB  = 16;
  localparam int DMA_HALF_BIT = 21;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_REC} stb_state_e;

  typedef struct packed {
    logic [TICK_W-1:0] acc;
    logic [TICK_W-1:0] rec;
    logic              half;
  } phase_t;

  function automatic logic [TICK_W-1:0] clamp1(input logic [TICK_W-1:0] v);
    return (v == '0) ? TICK_W'(1) : v;
  endfunction

  function automatic phase_t decode_word(input logic [WORD_W-1:0] w, input logic dma);
    phase_t p;
    if (dma) begin
      p.acc  = clamp1(w[DMA_ACC_LSB +: TICK_W]);
      p.rec  = clamp1(w[DMA_REC_LSB +: TICK_W]);
      p.half = w[DMA_HALF_BIT];
    end else begin
      p.acc  = clamp1(w[PIO_ACC_LSB +: TICK_W]);
      p.rec  = clamp1(w[PIO_REC_LSB +: TICK_W]);
      p.half = 1'b0;
    end
    return p;
  endfunction
endpackage

// File: rtl/stb_word_bank.sv
module stb_word_bank
  import stb_pkg::*;
#(
  parameter int NDEV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cur_word
);
  localparam logic [1:0] SEL_ADDR = 2'(NDEV);

  logic [WORD_W-1:0] words [NDEV];
  logic [SEL_W-1:0]  sel_q;

  for (genvar g = 0; g < NDEV; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   words[g] <= '0;
      else if (wr_en && wr_addr == 2'(g))           words[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               sel_q <= '0;
    else if (wr_en && wr_addr == SEL_ADDR)    sel_q <= wr_data[SEL_W-1:0];
  end

  assign cur_word = words[sel_q[SEL_DEV_BIT]];
endmodule

// File: rtl/stb_sequencer.sv
module stb_sequencer
  import stb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dma,
  input  logic              req_write,
  input  logic [WORD_W-1:0] cur_word,
  output logic              stb_core,
  output logic              write_q,
  output logic              half_q,
  output logic              req_ack,
  output logic              busy,
  output logic              start,
  output logic [WORD_W-1:0] active_word
);
  stb_state_e        state;
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] rec_q;
  phase_t            ph;

  assign ph    = decode_word(cur_word, req_dma);
  assign start = (state == ST_IDLE) && req_valid && !req_ack;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      rec_q       <= '0;
      half_q      <= 1'b0;
      write_q     <= 1'b0;
      stb_core    <= 1'b0;
      req_ack     <= 1'b0;
      active_word <= '0;
    end else begin
      req_ack <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          active_word <= cur_word;
          cnt         <= ph.acc - TICK_W'(1);
          rec_q       <= ph.rec;
          half_q      <= ph.half;
          write_q     <= req_write;
          stb_core    <= 1'b1;
          state       <= ST_ACC;
        end
        ST_ACC: if (cnt == '0) begin
          stb_core <= 1'b0;
          cnt      <= rec_q - TICK_W'(1);
          state    <= ST_REC;
        end else begin
          cnt <= cnt - TICK_W'(1);
        end
        ST_REC: if (cnt == '0) begin
          req_ack <= 1'b1;
          state   <= ST_IDLE;
        end else begin
          cnt <= cnt - TICK_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stb_half_ext.sv
module stb_half_ext (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_core,
  input  logic half_en,
  output logic stb_out
);
  logic ext_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= stb_core & half_en;
  end

  assign stb_out = stb_core | ext_q;
endmodule

// File: rtl/stb_timer.sv
module stb_timer
  import stb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_dma,
  input  logic              req_write,
  output logic              req_ack,
  output logic              rd_stb,
  output logic              wr_stb
);
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] active_word;
  logic stb_core, write_q, half_q, busy, start, stb_any;

  stb_word_bank #(.NDEV(2)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .cur_word(cur_word)
  );

  stb_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dma(req_dma),
    .req_write(req_write), .cur_word(cur_word), .stb_core(stb_core),
    .write_q(write_q), .half_q(half_q), .req_ack(req_ack), .busy(busy),
    .start(start), .active_word(active_word)
  );

  stb_half_ext u_half (
    .clk(clk), .rst_n(rst_n), .stb_core(stb_core), .half_en(half_q),
    .stb_out(stb_any)
  );

  assign rd_stb = stb_any & ~write_q;
  assign wr_stb = stb_any &  write_q;
endmodule

// File: rtl/stb_timer_chk.sv
module stb_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        stb_core,
  input logic        req_ack,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic [31:0] active_word
);
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  assert_ack_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (!rd_stb && !wr_stb));

  assert_start_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> stb_core);

  assert_word_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(active_word));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !stb_core);
endmodule

bind stb_timer stb_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .stb_core(stb_core),
  .req_ack(req_ack), .rd_stb(rd_stb), .wr_stb(wr_stb), .active_word(active_word)
);

// File: tb/tb_stb_timer.sv
module tb_stb_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_dma = 1'b0, req_write = 1'b0;
  logic req_ack, rd_stb, wr_stb;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stb_timer dut (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int fld(input logic [31:0] w, input int lsb);
    int v = int'((w >> lsb) & 32'h1f);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2; cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2; cfg_wr_en = 0;
  endtask

  task automatic run(input logic wr, input logic dma, input logic [31:0] w,
                     input string rq, input bit mid, input logic [1:0] ma,
                     input logic [31:0] md);
    int ea, er, eh, hi, lo, wrong, idx;
    bit seen;
    ea = dma ? fld(w, 11) : fld(w, 0);
    er = dma ? fld(w, 16) : fld(w, 5);
    eh = (dma && w[21]) ? 1 : 0;
    hi = 0; lo = 0; wrong = 0; idx = 0; seen = 0;
    @(posedge clk); #2; req_valid = 1; req_write = wr; req_dma = dma;
    while (!seen && idx < 200) begin
      @(posedge clk); #2;
      if (mid && idx == 2) begin cfg_wr_en = 1; cfg_addr = ma; cfg_wdata = md; end
      if (mid && idx == 4) cfg_wr_en = 0;
      idx++;
      if (req_ack) seen = 1;
      else begin
        for (int h = 0; h < 2; h++) begin
          if (h == 1) #4;
          if (wr ? wr_stb : rd_stb) hi++; else lo++;
          if (wr ? rd_stb : wr_stb) wrong++;
        end
      end
    end
    req_valid = 0; cfg_wr_en = 0;
    chk(hi == 2*ea + eh, {rq, " strobe half-clocks high"}, hi, 2*ea + eh);
    chk(lo == 2*er - eh, {rq, " recovery half-clocks"}, lo, 2*er - eh);
    chk(wrong == 0 && seen, {rq, " R7 other strobe idle / ack seen"}, wrong, 0);
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, sel, hold_w;
    void'($urandom(32'd2024));
    #20; rst_n = 1;
    @(posedge clk); #2;
    // R1 reset state
    chk(!rd_stb && !wr_stb && !req_ack, "R1 outputs idle after reset",
        int'({rd_stb, wr_stb, req_ack}), 0);
    run(0, 0, 32'h0, "R1 zero words clamp", 0, 0, 0);
    // R2 device select on bit 4
    w0 = 32'h0000_0043; w1 = 32'h0000_0087;
    cfg(0, w0); cfg(1, w1); cfg(2, 32'h10);
    run(0, 0, w1, "R2 dev1 chosen R3 R4", 0, 0, 0);
    cfg(2, 32'hEF);
    run(1, 0, w0, "R2 dev0 other bits ignored", 0, 0, 0);
    // R5 DMA fields, R6 half tick
    w0 = (32'd3 << 11) | (32'd2 << 16) | (32'd1 << 21) | 32'h3FF;
    cfg(0, w0);
    run(0, 1, w0, "R5 R6 dma half", 0, 0, 0);
    run(1, 0, w0, "R6 half ignored in pio", 0, 0, 0);
    cfg(0, w0 & ~(32'd1 << 21));
    run(1, 1, w0 & ~(32'd1 << 21), "R5 dma no half", 0, 0, 0);
    // R8 mid-cycle writes
    w1 = 32'h0000_00A6;
    cfg(1, w1); cfg(2, 32'h10);
    run(0, 0, w1, "R8 word write mid-cycle", 1, 2'd1, 32'h0000_0022);
    run(0, 0, 32'h0000_0022, "R8 new word next cycle", 1, 2'd2, 32'h00);
    run(0, 0, w0 & ~(32'd1 << 21), "R8 select change next cycle", 0, 0, 0);
    // R9 held request
    hold_w = 32'h0000_0022;
    cfg(0, hold_w);
    @(posedge clk); #2; req_valid = 1; req_write = 0; req_dma = 0;
    for (int i = 0; i < 50 && !req_ack; i++) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    chk(!rd_stb, "R9 no strobe during ack-clear cycle", int'(rd_stb), 0);
    @(posedge clk); #2;
    chk(rd_stb, "R9 held request restarts", int'(rd_stb), 1);
    req_valid = 0;
    for (int i = 0; i < 50 && !req_ack; i++) begin @(posedge clk); #2; end
    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic wr, dma;
      w0 = $urandom; w1 = $urandom; sel = $urandom & 32'hFF;
      wr = 1'($urandom); dma = 1'($urandom);
      cfg(0, w0); cfg(1, w1); cfg(2, sel);
      run(wr, dma, sel[4] ? w1 : w0, "R2 R3 R4 R5 R6 random", 0, 0, 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule